// File: doc/BRIEF.md
# Multi-Channel DMA Transfer Termination Controller

This block moves data between two memory locations on several independent channels. Each channel has a source pointer, a destination pointer, a remaining-transfer count and a small control word (enable, interrupt enable, end flag, transfer size). A shared global word holds a master enable, an address-error flag and a non-maskable-interrupt flag. A one-cycle pulse on a channel's request input marks one transfer as pending. The sequencer then serves pending channels one transfer at a time, lowest channel number first. Each transfer is a read bus cycle at the source followed by a write bus cycle at the destination.

The block separates normal completion from suspension. When the count reaches zero, the channel sets its end flag and, if allowed, raises its interrupt. Suspension does not set the end flag and leaves the pointers and count on the next transfer to run. It happens when software disables the channel, when the master enable is cleared, when the NMI flag is set, or when a misaligned address raises the address-error flag. An address error blocks all request acceptance. It stays set until software reads the global word and then writes the flag back to zero.

The sequencer has five states. IDLE goes to CHECK when a channel is eligible, and latches the winning channel. CHECK goes back to IDLE on a stop condition or on a misaligned address; the misaligned case raises the error. Otherwise CHECK goes to READ. READ holds its strobe until acknowledged, then goes to IDLE if a stop condition is present and to WRITE if not. WRITE holds its strobe until acknowledged and then goes to DONE. DONE updates the channel and returns to IDLE.

Top module: `dma_term_ctrl`

## Requirements
- R1: After reset, every channel register reads 0, the global word reads 0, no interrupt is raised and no bus strobe is active. Register addresses:
  - Channel c occupies 4c+0 (source), 4c+1 (destination), 4c+2 (count) and 4c+3 (control).
  - The control word holds enable at bit 0, interrupt enable at bit 1, end flag at bit 2 and size code at bits 4:3. Size code 0 means 1 byte, 1 means 2 bytes, and 2 or 3 means 4 bytes.
  - The global word sits at 4×channels and holds master enable at bit 0, address error at bit 1 and NMI flag at bit 2.
- R2: A transfer performs a read at the source address and then writes the read data to the destination address. Afterwards both addresses have advanced by the transfer size and the count has dropped by one.
- R3: When a transfer brings the count to zero, the channel's end flag is set and no further transfers start on that channel.
- R4: A channel's interrupt output is high exactly while its end flag and its interrupt enable are both 1.
- R5: Clearing a channel's enable stops only that channel. The end flag is not set, and the pointers and count keep their values.
- R6: No transfer starts on any channel while the master enable is 0 or the NMI flag is 1. A rising edge on the nmi input sets the NMI flag, and writing 0 to it clears it. A pending request is served once the stop condition is removed.
- R7: A source or destination address that is not a multiple of the transfer size sets the address-error flag. No bus cycle is issued for that transfer, and the pointers and count keep the values of the transfer that would have run.
- R8: Writing 0 to the address-error flag clears it only if the global word was read while the flag was 1. Without such a read the flag stays 1.
- R9: Request pulses that arrive while the address-error flag is 1 are discarded, and raising the flag drops all pending requests. After recovery a new pulse is needed.
- R10: When several channels have a pending transfer, the lowest-numbered channel is served first.
- R11: Writing 1 to the end flag has no effect and writing 0 clears it. A channel with its end flag at 1 keeps its pending request but does not start it until the flag is cleared.
- R12: A stop that arrives during a read bus cycle lets that read complete. No write follows, and the count is not decremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used for the error handshake) |
| reg_addr | input | RAW | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| xfer_req | input | NCH | One-cycle transfer request pulse per channel |
| nmi | input | 1 | Non-maskable interrupt; rising edge sets the NMI flag |
| mem_req | output | 1 | Memory bus cycle strobe |
| mem_we | output | 1 | 1 for a write cycle, 0 for a read cycle |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory bus cycle acknowledge |
| irq | output | NCH | Per-channel end-of-transfer interrupt |

## Verification
The memory acknowledge is tied straight to the strobe, so a request pulse seen at one rising edge produces the following sequence:
- the sequencer enters CHECK at the second edge;
- the read is acknowledged at the fourth edge;
- the write is acknowledged at the fifth edge;
- pointers, count and end flag are updated at the sixth edge.

The bench therefore reads registers eight cycles after a pulse. An address error is visible in the global word three edges after the pulse. Interrupts and register writes take effect at the edge that ends the write strobe. All values are sampled one time unit after a falling edge, well away from the active edge.

// File: rtl/dma_term_pkg.sv
package dma_term_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_READ,
        S_WRITE,
        S_DONE
    } seq_state_t;

    localparam int CTL_EN   = 0;
    localparam int CTL_IE   = 1;
    localparam int CTL_TEND = 2;
    localparam int CTL_SZLO = 3;
    localparam int CTL_SZHI = 4;

    localparam int GLB_MEN  = 0;
    localparam int GLB_AE   = 1;
    localparam int GLB_NMIF = 2;

    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        unique case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  elig,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |elig;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dma_align_chk.sv
module dma_align_chk #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic [1:0]    size_code,
    output logic          bad
);
    always_comb begin
        unique case (size_code)
            2'd0:    bad = 1'b0;
            2'd1:    bad = src[0] | dst[0];
            default: bad = (|src[1:0]) | (|dst[1:0]);
        endcase
    end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_term_pkg::*;
#(
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any_elig,
    input  logic [IW-1:0] pick,
    input  logic          misaligned,
    input  logic          stop,
    input  logic          mem_ack,
    output logic [IW-1:0] sel_q,
    output logic          mem_req,
    output logic          mem_we,
    output logic          take,
    output logic          upd,
    output logic          ae_set
);
    seq_state_t state_q, state_d;
    logic [IW-1:0] sel_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        unique case (state_q)
            S_IDLE: begin
                if (any_elig) begin
                    state_d = S_CHECK;
                    sel_d   = pick;
                end
            end
            S_CHECK: begin
                if (stop || misaligned) state_d = S_IDLE;
                else                    state_d = S_READ;
            end
            S_READ: begin
                if (mem_ack) state_d = stop ? S_IDLE : S_WRITE;
            end
            S_WRITE: begin
                if (mem_ack) state_d = S_DONE;
            end
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req = 1'b0;
        mem_we  = 1'b0;
        take    = 1'b0;
        upd     = 1'b0;
        ae_set  = 1'b0;
        unique case (state_q)
            S_IDLE:  ;
            S_CHECK: ae_set = !stop && misaligned;
            S_READ: begin
                mem_req = 1'b1;
                take    = mem_ack && !stop;
            end
            S_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            S_DONE:  upd = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/dma_term_ctrl.sv
module dma_term_ctrl
    import dma_term_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 8,
    parameter int DW  = 32,
    localparam int RAW = $clog2(4 * NCH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic           reg_rd,
    input  logic [RAW-1:0] reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    input  logic [NCH-1:0] xfer_req,
    input  logic           nmi,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_ack,
    output logic [NCH-1:0] irq
);
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [RAW-1:0] GLB_ADDR = RAW'(4 * NCH);

    logic [NCH-1:0][AW-1:0] sar_q, dar_q;
    logic [NCH-1:0][CW-1:0] cnt_q;
    logic [NCH-1:0][1:0]    sz_q;
    logic [NCH-1:0]         en_q, ie_q, tend_q, pend_q;
    logic                   men_q, ae_q, nmif_q, ae_seen_q, nmi_d;
    logic [DW-1:0]          data_q;

    logic                   is_glb, ch_hit;
    logic [RAW-3:0]         ch_idx;
    logic [NCH-1:0]         elig;
    logic                   any_elig, misaligned, stop, gstop;
    logic [IW-1:0]          pick, sel_q;
    logic                   take, upd, ae_set;
    logic [AW-1:0]          step;
    logic                   unused_wdata;

    assign unused_wdata = ^reg_wdata[31:AW];

    assign is_glb = (reg_addr == GLB_ADDR);
    assign ch_idx = reg_addr[RAW-1:2];
    assign ch_hit = !is_glb && (int'(ch_idx) < NCH);
    assign gstop  = !men_q || ae_q || nmif_q;
    assign stop   = gstop || !en_q[sel_q];
    assign step   = AW'(size_bytes(sz_q[sel_q]));

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_elig
            assign elig[g] = pend_q[g] && en_q[g] && !tend_q[g] &&
                             (cnt_q[g] != '0) && !gstop;
            assign irq[g]  = tend_q[g] && ie_q[g];
        end
    endgenerate

    dma_prio_pick #(.N(NCH)) u_pick (
        .elig (elig),
        .any  (any_elig),
        .idx  (pick)
    );

    dma_align_chk #(.AW(AW)) u_align (
        .src       (sar_q[sel_q]),
        .dst       (dar_q[sel_q]),
        .size_code (sz_q[sel_q]),
        .bad       (misaligned)
    );

    dma_seq #(.IW(IW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_elig   (any_elig),
        .pick       (pick),
        .misaligned (misaligned),
        .stop       (stop),
        .mem_ack    (mem_ack),
        .sel_q      (sel_q),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .take       (take),
        .upd        (upd),
        .ae_set     (ae_set)
    );

    assign mem_addr  = mem_we ? dar_q[sel_q] : sar_q[sel_q];
    assign mem_wdata = data_q;

    // register file; hardware updates come last and win over software writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sar_q     <= '0;
            dar_q     <= '0;
            cnt_q     <= '0;
            sz_q      <= '0;
            en_q      <= '0;
            ie_q      <= '0;
            tend_q    <= '0;
            pend_q    <= '0;
            men_q     <= 1'b0;
            ae_q      <= 1'b0;
            nmif_q    <= 1'b0;
            ae_seen_q <= 1'b0;
            nmi_d     <= 1'b0;
            data_q    <= '0;
        end else begin
            nmi_d <= nmi;
            if (reg_wr) begin
                for (int i = 0; i < NCH; i++) begin
                    if (ch_hit && int'(ch_idx) == i) begin
                        unique case (reg_addr[1:0])
                            2'd0: sar_q[i] <= reg_wdata[AW-1:0];
                            2'd1: dar_q[i] <= reg_wdata[AW-1:0];
                            2'd2: cnt_q[i] <= reg_wdata[CW-1:0];
                            default: begin
                                en_q[i] <= reg_wdata[CTL_EN];
                                ie_q[i] <= reg_wdata[CTL_IE];
                                sz_q[i] <= reg_wdata[CTL_SZHI:CTL_SZLO];
                                if (!reg_wdata[CTL_TEND]) tend_q[i] <= 1'b0;
                            end
                        endcase
                    end
                end
                if (is_glb) begin
                    men_q <= reg_wdata[GLB_MEN];
                    if (!reg_wdata[GLB_AE] && ae_seen_q) begin
                        ae_q      <= 1'b0;
                        ae_seen_q <= 1'b0;
                    end
                    if (!reg_wdata[GLB_NMIF]) nmif_q <= 1'b0;
                end
            end else if (reg_rd && is_glb && ae_q) begin
                ae_seen_q <= 1'b1;
            end
            for (int i = 0; i < NCH; i++) begin
                if (xfer_req[i] && !ae_q) pend_q[i] <= 1'b1;
            end
            if (nmi && !nmi_d) nmif_q <= 1'b1;
            if (take) data_q <= mem_rdata;
            if (upd) begin
                sar_q[sel_q]  <= sar_q[sel_q] + step;
                dar_q[sel_q]  <= dar_q[sel_q] + step;
                cnt_q[sel_q]  <= cnt_q[sel_q] - CW'(1);
                pend_q[sel_q] <= 1'b0;
                if (cnt_q[sel_q] == CW'(1)) tend_q[sel_q] <= 1'b1;
            end
            if (ae_set) begin
                ae_q      <= 1'b1;
                ae_seen_q <= 1'b0;
                pend_q    <= '0;
            end
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (is_glb) begin
            reg_rdata[GLB_MEN]  = men_q;
            reg_rdata[GLB_AE]   = ae_q;
            reg_rdata[GLB_NMIF] = nmif_q;
        end
        for (int i = 0; i < NCH; i++) begin
            if (ch_hit && int'(ch_idx) == i) begin
                unique case (reg_addr[1:0])
                    2'd0: reg_rdata = 32'(sar_q[i]);
                    2'd1: reg_rdata = 32'(dar_q[i]);
                    2'd2: reg_rdata = 32'(cnt_q[i]);
                    default: begin
                        reg_rdata[CTL_EN]            = en_q[i];
                        reg_rdata[CTL_IE]            = ie_q[i];
                        reg_rdata[CTL_TEND]          = tend_q[i];
                        reg_rdata[CTL_SZHI:CTL_SZLO] = sz_q[i];
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/dma_term_chk.sv
module dma_term_chk #(
    parameter int NCH = 4,
    parameter int CW  = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   mem_req,
    input logic                   mem_we,
    input logic                   ae,
    input logic                   ae_seen,
    input logic                   men,
    input logic                   nmif,
    input logic [NCH-1:0]         tend,
    input logic [NCH-1:0]         irq,
    input logic [NCH-1:0][CW-1:0] cnt
);
    // R7
    ae_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ae) |-> !mem_req);

    // R6
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req) && !mem_we) |-> $past(men && !ae && !nmif));

    // R8
    ae_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ae) |-> $past(ae_seen));

    // R2
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(mem_req && !mem_we));

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_ch
            // R3
            tend_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(tend[g]) |-> (cnt[g] == '0));
            // R4
            irq_tend_chk: assert property (@(posedge clk) disable iff (!rst_n)
                irq[g] |-> tend[g]);
        end
    endgenerate
endmodule

bind dma_term_ctrl dma_term_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mem_req (mem_req),
    .mem_we  (mem_we),
    .ae      (ae_q),
    .ae_seen (ae_seen_q),
    .men     (men_q),
    .nmif    (nmif_q),
    .tend    (tend_q),
    .irq     (irq),
    .cnt     (cnt_q)
);

// File: tb/tb_dma_term_ctrl.sv
`timescale 1ns/1ps
module tb_dma_term_ctrl;
    localparam int NCH = 4;
    localparam int AW  = 16;
    localparam int DW  = 32;
    localparam int RAW = $clog2(4 * NCH + 1);
    localparam logic [RAW-1:0] GLB = RAW'(16);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_wr = 1'b0, reg_rd = 1'b0;
    logic [RAW-1:0] reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic [NCH-1:0] xfer_req = '0;
    logic           nmi = 1'b0;
    logic           mem_req, mem_we, mem_ack;
    logic [AW-1:0]  mem_addr;
    logic [DW-1:0]  mem_wdata, mem_rdata;
    logic [NCH-1:0] irq;
    logic           ack_en = 1'b1;

    int checks = 0, fails = 0;
    int wr_n = 0, rd_n = 0;
    logic [AW-1:0] wlog [8];
    logic [AW-1:0] last_waddr;
    logic [DW-1:0] last_wdata;

    always #10 clk = ~clk;

    assign mem_ack   = mem_req && ack_en;
    assign mem_rdata = {16'hA5A5, mem_addr};

    dma_term_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .xfer_req(xfer_req), .nmi(nmi), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .irq(irq)
    );

    always @(posedge clk) begin
        if (mem_req && mem_ack) begin
            if (mem_we) begin
                wlog[wr_n & 7] <= mem_addr;
                last_waddr     <= mem_addr;
                last_wdata     <= mem_wdata;
                wr_n           <= wr_n + 1;
            end else begin
                rd_n <= rd_n + 1;
            end
        end
    end

    // vectors for channel 0: size, src, dst, count -> expected after one transfer
    localparam logic [1:0]  V_SZ  [4] = '{2'd0, 2'd1, 2'd2, 2'd2};
    localparam logic [15:0] V_SAR [4] = '{16'h0101, 16'h0100, 16'h1000, 16'h0FFC};
    localparam logic [15:0] V_DAR [4] = '{16'h0203, 16'h0300, 16'h2004, 16'h00F0};
    localparam logic [7:0]  V_CNT [4] = '{8'd3, 8'd1, 8'd5, 8'd1};
    localparam logic [15:0] E_SAR [4] = '{16'h0102, 16'h0102, 16'h1004, 16'h1000};
    localparam logic [15:0] E_DAR [4] = '{16'h0204, 16'h0302, 16'h2008, 16'h00F4};
    localparam logic [7:0]  E_CNT [4] = '{8'd2, 8'd0, 8'd4, 8'd0};
    localparam logic        E_TND [4] = '{1'b0, 1'b1, 1'b0, 1'b1};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = RAW'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = RAW'(a);
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse(input logic [NCH-1:0] m);
        @(negedge clk);
        xfer_req = m;
        @(negedge clk);
        xfer_req = '0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int wb, rb;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        rd(16, v); chk("R1 global", v, 0);
        rd(15, v); chk("R1 ctrl3", v, 0);
        rd(10, v); chk("R1 cnt2", v, 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 mem_req", 32'(mem_req), 0);

        wr(16, 32'h1);

        // R2 R3 R4 vector table on channel 0
        for (int k = 0; k < 4; k++) begin
            wr(0, 32'(V_SAR[k]));
            wr(1, 32'(V_DAR[k]));
            wr(2, 32'(V_CNT[k]));
            wr(3, {27'b0, V_SZ[k], 3'b011});
            pulse(4'b0001);
            wait_cyc(8);
            rd(0, v); chk("R2 src advance", v, 32'(E_SAR[k]));
            rd(1, v); chk("R2 dst advance", v, 32'(E_DAR[k]));
            rd(2, v); chk("R2 count", v, 32'(E_CNT[k]));
            chk("R2 write addr", 32'(last_waddr), 32'(V_DAR[k]));
            chk("R2 write data", last_wdata, {16'hA5A5, V_SAR[k]});
            rd(3, v); chk("R3 end flag", 32'(v[2]), 32'(E_TND[k]));
            chk("R4 irq", 32'(irq[0]), 32'(E_TND[k]));
        end

        // R11 end flag blocks start; writing 1 does not clear; writing 0 clears
        wr(2, 32'd2);
        wr(3, 32'h17);
        pulse(4'b0001);
        wait_cyc(8);
        rd(2, v); chk("R11 blocked count", v, 2);
        rd(3, v); chk("R11 flag kept", 32'(v[2]), 1);
        chk("R4 irq held", 32'(irq[0]), 1);
        wr(3, 32'h13);
        chk("R4 irq dropped", 32'(irq[0]), 0);
        wait_cyc(8);
        rd(2, v); chk("R11 resumed count", v, 1);

        // R10 priority
        wr(4, 32'h0400); wr(5, 32'h0500); wr(6, 1); wr(7, 32'h1);
        wr(8, 32'h0600); wr(9, 32'h0700); wr(10, 1); wr(11, 32'h1);
        wb = wr_n;
        pulse(4'b0110);
        wait_cyc(16);
        chk("R10 two writes", 32'(wr_n - wb), 2);
        chk("R10 first ch1", 32'(wlog[wb & 7]), 32'h0500);
        chk("R10 second ch2", 32'(wlog[(wb + 1) & 7]), 32'h0700);
        chk("R4 irq off when ie 0", 32'(irq[1]), 0);

        // R5 R12 disable during a read bus cycle
        wr(2, 32'd3);
        wb = wr_n; rb = rd_n;
        ack_en = 1'b0;
        pulse(4'b0001);
        wait_cyc(4);
        wr(3, 32'h12);
        ack_en = 1'b1;
        wait_cyc(6);
        chk("R12 read completed", 32'(rd_n - rb), 1);
        chk("R12 no write", 32'(wr_n - wb), 0);
        rd(2, v); chk("R5 count kept", v, 3);
        rd(0, v); chk("R5 src kept", v, 32'h1004);
        rd(3, v); chk("R5 no end flag", 32'(v[2]), 0);

        // R6 master disable and NMI
        wr(16, 32'h0);
        wr(3, 32'h13);
        pulse(4'b0001);
        wait_cyc(8);
        rd(2, v); chk("R6 master off", v, 3);
        wr(16, 32'h1);
        wait_cyc(8);
        rd(2, v); chk("R6 master on", v, 2);
        @(negedge clk); nmi = 1'b1;
        @(negedge clk); nmi = 1'b0;
        pulse(4'b0001);
        wait_cyc(8);
        rd(2, v); chk("R6 nmi holds", v, 2);
        rd(16, v); chk("R6 nmi flag", v, 32'h5);
        wr(16, 32'h1);
        wait_cyc(8);
        rd(2, v); chk("R6 nmi cleared", v, 1);

        // R7 R8 R9 address error
        wr(0, 32'h1001);
        wr(2, 32'd2);
        wb = wr_n; rb = rd_n;
        pulse(4'b0001);
        wait_cyc(8);
        chk("R7 no bus cycle", 32'(rd_n - rb), 0);
        wr(16, 32'h1);
        pulse(4'b0001);
        wr(0, 32'h1000);
        rd(16, v); chk("R8 clear refused", v, 32'h3);
        rd(2, v); chk("R7 count kept", v, 2);
        wr(16, 32'h1);
        wait_cyc(8);
        rd(16, v); chk("R8 cleared", v, 32'h1);
        rd(2, v); chk("R9 request dropped", v, 2);
        chk("R7 no write", 32'(wr_n - wb), 0);
        pulse(4'b0001);
        wait_cyc(8);
        rd(2, v); chk("R9 new request", v, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule